// File: doc/BRIEF.md
# Lossy fast-channel value mailbox

This block is a bank of value slots written by a sender and read by a receiver. It behaves like a small RAM in which every write raises an event for that slot. There is no flow control and no acknowledge path. The sender may overwrite a slot at any moment, and the receiver always sees the newest value. Any value that is overwritten before it is read is lost, and that is intended.

Each slot has a pending bit. The bit sets when a sender write completes and stays set until the receiver clears it with a write-one-to-clear mask. Slots are arranged in fixed groups of `GRP_SLOTS`. Each group exposes a summary bit and a maskable group interrupt. Per-slot and per-group interrupts are also gated by one global enable, which is bit 2 of a receiver control word.

The slot word is 32 or 64 bits (`WORD_W`). The sender port is always 32 bits wide, so in 64-bit mode it writes a slot as two halves, and only the write of the upper half completes a transfer. The number of slots is limited to 1024 for 32-bit words and 512 for 64-bit words, and `NUM_SLOTS` must be a multiple of `GRP_SLOTS`.

Reads go through a two-state sequencer:
- **RD_IDLE** moves to **RD_BUSY** on `rd_req`.
- **RD_BUSY** stays in RD_BUSY while `rd_req` is held.
- **RD_BUSY** returns to RD_IDLE when `rd_req` is low.
- `rd_valid` is high in RD_BUSY.

Top module: `fch_mailbox`

## Requirements
- R1: After reset, every slot holds zero, all pending bits, group summaries and interrupts are 0, both enables are off and `rd_valid` is 0.
- R2: A read request sampled at a clock edge moves the sequencer to RD_BUSY. On the next cycle `rd_valid` is 1 and `rd_data` holds the slot's most recent value, including a write made at that same edge. `rd_valid` drops one cycle after `rd_req` goes low.
- R3: A transfer sets the slot's pending bit on the following cycle. With `WORD_W`=32, any write is a transfer and `snd_hi` is ignored. With `WORD_W`=64, `snd_hi`=0 writes bits 31:0 of the slot without an event, and `snd_hi`=1 writes bits 63:32 and completes the transfer.
- R4: A later write replaces the slot's value with no handshake. A slot that is already pending stays pending.
- R5: When `clr_we` is high, bit b of `clr_mask` clears the pending bit of slot `clr_grp*GRP_SLOTS+b`. A transfer to that slot in the same cycle wins, and the bit stays set. Without a write or a clear, pending bits do not change.
- R6: `grp_pend[g]` is the OR of the pending bits of slots g*GRP_SLOTS to g*GRP_SLOTS+GRP_SLOTS-1, regardless of any enable.
- R7: A write of `ctl_data` with `ctl_we` loads the global enable from bit 2, and all other bits are ignored. `slot_irq[i]` is pending[i] AND the global enable. `grp_irq[g]` is `grp_pend[g]` AND group enable g AND the global enable.
- R8: `gen_we` loads the per-group enable word from `gen_data`, where bit g enables group g.
- R9: A write to a slot index of `NUM_SLOTS` or above changes nothing. A read of such an index returns zero. A clear naming a group index of `NUM_SLOTS/GRP_SLOTS` or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_we | input | 1 | Sender write strobe |
| snd_idx | input | IDX_W | Sender slot index |
| snd_hi | input | 1 | Upper-half select (64-bit mode) |
| snd_data | input | 32 | Sender write data |
| rd_req | input | 1 | Receiver read request |
| rd_idx | input | IDX_W | Receiver slot index |
| rd_valid | output | 1 | Read data valid (RD_BUSY) |
| rd_data | output | WORD_W | Read data |
| clr_we | input | 1 | Pending clear strobe |
| clr_grp | input | GRP_W | Group addressed by the clear |
| clr_mask | input | GRP_SLOTS | Write-one-to-clear mask within the group |
| ctl_we | input | 1 | Control word write strobe |
| ctl_data | input | 32 | Control word, bit 2 is the global enable |
| gen_we | input | 1 | Group enable write strobe |
| gen_data | input | NUM_SLOTS/GRP_SLOTS | Group enable word |
| pend | output | NUM_SLOTS | Per-slot pending bits |
| grp_pend | output | NUM_SLOTS/GRP_SLOTS | Per-group pending summary |
| slot_irq | output | NUM_SLOTS | Per-slot transfer interrupts |
| grp_irq | output | NUM_SLOTS/GRP_SLOTS | Per-group transfer interrupts |

## Verification
The properties assume that the index inputs are stable for the whole cycle in which their strobe is high. They also assume that in 64-bit mode the sender writes the lower half before the upper half whenever a consistent value matters. The stimulus drives every strobe and index together on the falling edge and always orders halves low then high, except in the overwrite test, which mixes halves on purpose to show the lossy result. Out-of-range indices are sent only in the dedicated range test, so the pending-set property guards its index with the slot count.

// File: rtl/fch_pkg.sv
package fch_pkg;
    localparam int unsigned HALF_W  = 32;
    localparam int unsigned GIE_BIT = 2;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_BUSY = 1'b1
    } rd_state_e;
endpackage

// File: rtl/fch_store.sv
module fch_store
    import fch_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_hi,
    input  logic [HALF_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]     look_idx,
    output logic [WORD_W-1:0]    look_word,
    output logic [NUM_SLOTS-1:0] evt
);
    localparam int unsigned HALVES = WORD_W / HALF_W;

    logic [HALVES-1:0] half_sel;
    logic              fire;
    logic [WORD_W-1:0] word_w [NUM_SLOTS];

    generate
        if (HALVES == 1) begin : g_single
            logic unused_hi;
            assign unused_hi = wr_hi;
            assign half_sel  = 1'b1;
            assign fire      = 1'b1;
        end else begin : g_split
            assign half_sel = {wr_hi, ~wr_hi};
            assign fire     = wr_hi;
        end
    endgenerate

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic              hit;
        logic [WORD_W-1:0] word_q;

        assign hit = wr_en && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                for (int h = 0; h < HALVES; h++) begin
                    if (half_sel[h]) word_q[h*HALF_W +: HALF_W] <= wr_data;
                end
            end
        end

        assign word_w[s] = word_q;
        assign evt[s]    = hit && fire;
    end

    // Read view with same-cycle forwarding of the half being written
    always_comb begin
        look_word = '0;
        if (32'(look_idx) < NUM_SLOTS) begin
            look_word = word_w[look_idx];
            if (wr_en && (wr_idx == look_idx)) begin
                for (int h = 0; h < HALVES; h++) begin
                    if (half_sel[h]) look_word[h*HALF_W +: HALF_W] = wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/fch_pending.sv
module fch_pending #(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned GRP_SLOTS = 2,
    parameter int unsigned NUM_GRPS  = 3,
    parameter int unsigned GRP_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] evt,
    input  logic                 clr_en,
    input  logic [GRP_W-1:0]     clr_grp,
    input  logic [GRP_SLOTS-1:0] clr_mask,
    output logic [NUM_SLOTS-1:0] pend,
    output logic [NUM_GRPS-1:0]  grp_pend
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bit
        localparam int unsigned GI = s / GRP_SLOTS;
        localparam int unsigned BI = s % GRP_SLOTS;
        logic clr_hit;
        logic pend_q;

        assign clr_hit = clr_en && (clr_grp == GRP_W'(GI)) && clr_mask[BI];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend_q <= 1'b0;
            else if (evt[s])  pend_q <= 1'b1;   // a new transfer beats a clear
            else if (clr_hit) pend_q <= 1'b0;
        end

        assign pend[s] = pend_q;
    end

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        assign grp_pend[g] = |pend[g*GRP_SLOTS +: GRP_SLOTS];
    end
endmodule

// File: rtl/fch_irq.sv
module fch_irq
    import fch_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned NUM_GRPS  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [31:0]          ctl_data,
    input  logic                 gen_we,
    input  logic [NUM_GRPS-1:0]  gen_data,
    input  logic [NUM_SLOTS-1:0] pend,
    input  logic [NUM_GRPS-1:0]  grp_pend,
    output logic                 gie,
    output logic [NUM_SLOTS-1:0] slot_irq,
    output logic [NUM_GRPS-1:0]  grp_irq
);
    logic                gie_q;
    logic [NUM_GRPS-1:0] gen_q;
    logic [30:0]         unused_ctl;

    assign unused_ctl = {ctl_data[31:GIE_BIT+1], ctl_data[GIE_BIT-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            gen_q <= '0;
        end else begin
            if (ctl_we) gie_q <= ctl_data[GIE_BIT];
            if (gen_we) gen_q <= gen_data;
        end
    end

    assign gie      = gie_q;
    assign slot_irq = pend & {NUM_SLOTS{gie_q}};
    assign grp_irq  = grp_pend & gen_q & {NUM_GRPS{gie_q}};
endmodule

// File: rtl/fch_rd_fsm.sv
module fch_rd_fsm
    import fch_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] word_in,
    output logic              valid,
    output logic [WORD_W-1:0] data
);
    rd_state_e         state_q, state_d;
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (req)  state_d = RD_BUSY;
            RD_BUSY: if (!req) state_d = RD_IDLE;
            default:           state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   data_q <= '0;
        else if (req) data_q <= word_in;
    end

    always_comb begin
        valid = (state_q == RD_BUSY);
        data  = data_q;
    end
endmodule

// File: rtl/fch_mailbox.sv
module fch_mailbox
    import fch_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 6,
    parameter  int unsigned WORD_W    = 32,
    parameter  int unsigned GRP_SLOTS = 2,
    localparam int unsigned NUM_GRPS  = NUM_SLOTS / GRP_SLOTS,
    localparam int unsigned IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned GRP_W     = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snd_we,
    input  logic [IDX_W-1:0]     snd_idx,
    input  logic                 snd_hi,
    input  logic [31:0]          snd_data,
    input  logic                 rd_req,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [WORD_W-1:0]    rd_data,
    input  logic                 clr_we,
    input  logic [GRP_W-1:0]     clr_grp,
    input  logic [GRP_SLOTS-1:0] clr_mask,
    input  logic                 ctl_we,
    input  logic [31:0]          ctl_data,
    input  logic                 gen_we,
    input  logic [NUM_GRPS-1:0]  gen_data,
    output logic [NUM_SLOTS-1:0] pend,
    output logic [NUM_GRPS-1:0]  grp_pend,
    output logic [NUM_SLOTS-1:0] slot_irq,
    output logic [NUM_GRPS-1:0]  grp_irq
);
    logic [NUM_SLOTS-1:0] evt;
    logic [WORD_W-1:0]    look_word;
    logic                 gie;

    fch_store #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(snd_we), .wr_idx(snd_idx), .wr_hi(snd_hi), .wr_data(snd_data),
        .look_idx(rd_idx), .look_word(look_word), .evt(evt)
    );

    fch_pending #(.NUM_SLOTS(NUM_SLOTS), .GRP_SLOTS(GRP_SLOTS),
                  .NUM_GRPS(NUM_GRPS), .GRP_W(GRP_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .clr_en(clr_we), .clr_grp(clr_grp), .clr_mask(clr_mask),
        .pend(pend), .grp_pend(grp_pend)
    );

    fch_irq #(.NUM_SLOTS(NUM_SLOTS), .NUM_GRPS(NUM_GRPS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_data(ctl_data), .gen_we(gen_we), .gen_data(gen_data),
        .pend(pend), .grp_pend(grp_pend),
        .gie(gie), .slot_irq(slot_irq), .grp_irq(grp_irq)
    );

    fch_rd_fsm #(.WORD_W(WORD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .req(rd_req), .word_in(look_word),
        .valid(rd_valid), .data(rd_data)
    );
endmodule

// File: rtl/fch_mailbox_chk.sv
module fch_mailbox_chk #(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned NUM_GRPS  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 snd_we,
    input logic [IDX_W-1:0]     snd_idx,
    input logic                 snd_hi,
    input logic                 rd_req,
    input logic                 rd_valid,
    input logic                 clr_we,
    input logic [NUM_SLOTS-1:0] pend,
    input logic                 gie,
    input logic [NUM_SLOTS-1:0] slot_irq,
    input logic [NUM_GRPS-1:0]  grp_irq
);
    p_event_sets_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_we && (32'(snd_idx) < NUM_SLOTS) && ((WORD_W == 32) || snd_hi))
        |=> pend[$past(snd_idx)]);

    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!snd_we && !clr_we) |=> (pend == $past(pend)));

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    p_valid_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> ((slot_irq == '0) && (grp_irq == '0)));
endmodule

bind fch_mailbox fch_mailbox_chk #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .IDX_W(IDX_W), .NUM_GRPS(NUM_GRPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .snd_we(snd_we), .snd_idx(snd_idx), .snd_hi(snd_hi),
    .rd_req(rd_req), .rd_valid(rd_valid), .clr_we(clr_we), .pend(pend),
    .gie(gie), .slot_irq(slot_irq), .grp_irq(grp_irq)
);

// File: tb/fch_mailbox_bench.sv
`timescale 1ns/1ps
module fch_mailbox_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Main instance: 64-bit slots, 6 slots, groups of 2
    logic        snd_we = 0, snd_hi = 0, rd_req = 0, clr_we = 0, ctl_we = 0, gen_we = 0;
    logic [2:0]  snd_idx = 0, rd_idx = 0;
    logic [31:0] snd_data = 0, ctl_data = 0;
    logic [1:0]  clr_grp = 0, clr_mask = 0;
    logic [2:0]  gen_data = 0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [5:0]  pend, slot_irq;
    logic [2:0]  grp_pend, grp_irq;

    fch_mailbox #(.NUM_SLOTS(6), .WORD_W(64), .GRP_SLOTS(2)) u_fch_mailbox (
        .clk(clk), .rst_n(rst_n), .snd_we(snd_we), .snd_idx(snd_idx), .snd_hi(snd_hi),
        .snd_data(snd_data), .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid),
        .rd_data(rd_data), .clr_we(clr_we), .clr_grp(clr_grp), .clr_mask(clr_mask),
        .ctl_we(ctl_we), .ctl_data(ctl_data), .gen_we(gen_we), .gen_data(gen_data),
        .pend(pend), .grp_pend(grp_pend), .slot_irq(slot_irq), .grp_irq(grp_irq)
    );

    // Second instance: 32-bit slots
    logic        s_we = 0, s_hi = 0, s_rreq = 0;
    logic [2:0]  s_idx = 0, s_ridx = 0;
    logic [31:0] s_data = 0;
    logic        s_rvalid;
    logic [31:0] s_rdata;
    logic [5:0]  s_pend, s_sirq;
    logic [2:0]  s_gpend, s_girq;

    fch_mailbox #(.NUM_SLOTS(6), .WORD_W(32), .GRP_SLOTS(2)) u_fch_w32 (
        .clk(clk), .rst_n(rst_n), .snd_we(s_we), .snd_idx(s_idx), .snd_hi(s_hi),
        .snd_data(s_data), .rd_req(s_rreq), .rd_idx(s_ridx), .rd_valid(s_rvalid),
        .rd_data(s_rdata), .clr_we(1'b0), .clr_grp(2'd0), .clr_mask(2'd0),
        .ctl_we(1'b0), .ctl_data(32'd0), .gen_we(1'b0), .gen_data(3'd0),
        .pend(s_pend), .grp_pend(s_gpend), .slot_irq(s_sirq), .grp_irq(s_girq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, bit hi, logic [31:0] d);
        @(negedge clk);
        snd_we = 1; snd_idx = idx[2:0]; snd_hi = hi; snd_data = d;
        @(negedge clk);
        snd_we = 0;
    endtask

    task automatic rd(int idx, output logic [63:0] v);
        @(negedge clk);
        rd_req = 1; rd_idx = idx[2:0];
        @(negedge clk);
        rd_req = 0;
        v = rd_data;
    endtask

    task automatic clr(int g, logic [1:0] m);
        @(negedge clk);
        clr_we = 1; clr_grp = g[1:0]; clr_mask = m;
        @(negedge clk);
        clr_we = 0;
    endtask

    task automatic ctl(logic [31:0] d);
        @(negedge clk);
        ctl_we = 1; ctl_data = d;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R1 pend", 64'(pend), 0);
        chk("R1 grp_pend", 64'(grp_pend), 0);
        chk("R1 irqs", 64'({slot_irq, grp_irq}), 0);
        chk("R1 rd_valid", 64'(rd_valid), 0);
        rd(3, v);
        chk("R1 slot zero", v, 0);
    endtask

    task automatic t_halves();
        logic [63:0] v;
        wr(1, 0, 32'hA1A1_0001);
        chk("R3 low half no event", 64'(pend), 0);
        rd(1, v);
        chk("R2 read low half", v, 64'h0000_0000_A1A1_0001);
        wr(1, 1, 32'hB1B1_0001);
        chk("R3 upper half event", 64'(pend), 64'b000010);
        rd(1, v);
        chk("R2 read full word", v, 64'hB1B1_0001_A1A1_0001);
    endtask

    task automatic t_overwrite();
        logic [63:0] v;
        wr(1, 0, 32'hA2A2_0002);
        rd(1, v);
        chk("R4 lossy mix", v, 64'hB1B1_0001_A2A2_0002);
        wr(1, 1, 32'hB2B2_0002);
        chk("R4 still pending", 64'(pend), 64'b000010);
        rd(1, v);
        chk("R4 newest value", v, 64'hB2B2_0002_A2A2_0002);
    endtask

    task automatic t_groups();
        wr(4, 1, 32'hC4C4_0004);
        chk("R6 pend", 64'(pend), 64'b010010);
        chk("R6 grp summary", 64'(grp_pend), 64'b101);
    endtask

    task automatic t_enables();
        chk("R7 gated off", 64'({slot_irq, grp_irq}), 0);
        ctl(32'h0000_0004);
        chk("R7 slot irq on", 64'(slot_irq), 64'b010010);
        chk("R8 grp irq masked", 64'(grp_irq), 0);
        @(negedge clk); gen_we = 1; gen_data = 3'b100;
        @(negedge clk); gen_we = 0;
        chk("R8 grp irq enabled", 64'(grp_irq), 64'b100);
        ctl(32'hFFFF_FFFB);
        chk("R7 only bit 2 matters", 64'({slot_irq, grp_irq}), 0);
        ctl(32'h0000_0004);
    endtask

    task automatic t_clear();
        clr(0, 2'b10);
        chk("R5 clear slot1", 64'(pend), 64'b010000);
        chk("R6 summary after clear", 64'(grp_pend), 64'b100);
        @(negedge clk);
        snd_we = 1; snd_idx = 3'd4; snd_hi = 1; snd_data = 32'hC4C4_0005;
        clr_we = 1; clr_grp = 2'd2; clr_mask = 2'b01;
        @(negedge clk);
        snd_we = 0; clr_we = 0;
        chk("R5 write beats clear", 64'(pend), 64'b010000);
        clr(2, 2'b01);
        chk("R5 clear slot4", 64'(pend), 0);
        chk("R7 irq follows clear", 64'({slot_irq, grp_irq}), 0);
    endtask

    task automatic t_range();
        logic [63:0] v;
        wr(6, 1, 32'hDEAD_0006);
        wr(7, 1, 32'hDEAD_0007);
        chk("R9 bad index no event", 64'(pend), 0);
        rd(7, v);
        chk("R9 bad index reads zero", v, 0);
        wr(5, 1, 32'hD5D5_0005);
        clr(3, 2'b11);
        chk("R9 bad group clear ignored", 64'(pend), 64'b100000);
        rd(5, v);
        chk("R9 good slot intact", v, 64'hD5D5_0005_0000_0000);
    endtask

    task automatic t_bypass();
        @(negedge clk);
        snd_we = 1; snd_idx = 3'd2; snd_hi = 1; snd_data = 32'hE2E2_0002;
        rd_req = 1; rd_idx = 3'd2;
        @(negedge clk);
        snd_we = 0; rd_req = 0;
        chk("R2 valid after one cycle", 64'(rd_valid), 1);
        chk("R2 same-edge write seen", rd_data, 64'hE2E2_0002_0000_0000);
        @(negedge clk);
        chk("R2 valid drops", 64'(rd_valid), 0);
    endtask

    task automatic t_word32();
        @(negedge clk);
        s_we = 1; s_idx = 3'd3; s_hi = 0; s_data = 32'hF3F3_0003;
        @(negedge clk);
        s_we = 0;
        chk("R3 w32 any write fires", 64'(s_pend), 64'b001000);
        @(negedge clk);
        s_we = 1; s_idx = 3'd0; s_hi = 1; s_data = 32'h0000_F0F0;
        s_rreq = 1; s_ridx = 3'd3;
        @(negedge clk);
        s_we = 0; s_rreq = 0;
        chk("R3 w32 hi ignored", 64'(s_pend), 64'b001001);
        chk("R2 w32 read", 64'(s_rdata), 64'hF3F3_0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_halves();
        t_overwrite();
        t_groups();
        t_enables();
        t_clear();
        t_range();
        t_bypass();
        t_word32();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule